// File: doc/BRIEF.md
# Conditional skip evaluator

This unit decides whether a 16-bit processor's conditional test instruction passes, and drives the instruction skipping that follows a failed test. The decoder presents the opcode with the two operand values, b and a, and raises `eval_valid`. The unit answers combinationally on `cond_true`. If a conditional test fails, the unit enters skip mode and raises `extra_cycle` for one cycle to charge the penalty cycle that a failed test costs.

In skip mode the fetch path hands instruction words to the unit through `word_valid` and `word_in`. The unit decodes each instruction's length from its operand fields and discards the instruction. It pulses `drop_done` once for each whole instruction discarded, and each pulse stands for one cycle of skipping. A discarded instruction that is itself a conditional extends the skip by one more instruction. Skip mode ends after the first non-conditional instruction has been fully discarded.

Top module: `cond_skip_unit`

## Requirements
- R1: After reset, `skip_active`, `extra_cycle` and `drop_done` are 0.
- R2: `cond_true` gives the test result for unsigned and bitwise tests. The opcodes are:
  - 0x10: b&a nonzero.
  - 0x11: b&a zero.
  - 0x12: b==a.
  - 0x13: b!=a.
  - 0x14: b>a.
  - 0x16: b<a.
- R3: Opcode 0x15 tests b>a and opcode 0x17 tests b<a, both as signed 16-bit two's-complement values. For any opcode outside 0x10..0x17, `cond_true` is 0.
- R4: Take a cycle in which `eval_valid` is 1, a conditional opcode is present, the test is false and the unit is not skipping. After that clock edge, `skip_active` is 1 and `extra_cycle` is 1 for exactly one cycle. A passing test changes neither output.
- R5: Two kinds of evaluation are ignored: one with a non-conditional opcode, and any evaluation made while `skip_active` is 1. Neither raises `extra_cycle` or starts a skip.
- R6: An instruction word holds the opcode in bits 4:0, the b code in bits 9:5 and the a code in bits 15:10. Some operand codes each add one following word: 0x10..0x17, 0x1e and 0x1f. So a discarded instruction spans 1 to 3 words, and `drop_done` is 1 during its last word.
- R7: When the word's opcode is 0x00, the b field is not an operand and adds no word. Such words are never treated as conditionals.
- R8: If a discarded instruction has an opcode in 0x10..0x17, skipping continues. `skip_active` falls after the last word of the first non-conditional instruction.
- R9: While `word_valid` is 0, the skip makes no progress and `drop_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_valid | input | 1 | Opcode and operands present an instruction to evaluate |
| opcode | input | 5 | Decoded opcode |
| opnd_b | input | 16 | Value of operand b |
| opnd_a | input | 16 | Value of operand a |
| word_valid | input | 1 | An instruction word is offered for discarding |
| word_in | input | 16 | Instruction word being skipped |
| cond_true | output | 1 | Test result for the current opcode and operands |
| skip_active | output | 1 | Unit is discarding instructions |
| extra_cycle | output | 1 | One-cycle penalty pulse after a failed test |
| drop_done | output | 1 | Last word of a discarded instruction is taken |

## Verification
Each test opcode is driven with operand pairs chosen so that the result flips between neighbouring cases: overlapping against disjoint bit masks, equal against off-by-one values, and values with the top bit set. The top-bit cases separate the unsigned comparisons from the signed ones. The skip path receives words of every length. Some of those lengths come from the b field and some from the a field, which exposes a miscount in either field. A special-group word carries a b field that would add a word if it were decoded as an operand. A chain of skipped conditionals distinguishes continuing the skip from ending it.

// File: rtl/cond_skip_unit.sv
module cond_skip_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval_valid,
  input  logic [4:0]   opcode,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] opnd_a,
  input  logic         word_valid,
  input  logic [15:0]  word_in,
  output logic         cond_true,
  output logic         skip_active,
  output logic         extra_cycle,
  output logic         drop_done
);

  function automatic logic takes_word(input logic [5:0] code);
    return (code[5:3] == 3'b010) || (code == 6'h1e) || (code == 6'h1f);
  endfunction

  logic       is_cond;
  logic [1:0] left_q;
  logic       chain_q;
  logic       skip_q;
  logic       extra_q;

  assign is_cond = (opcode[4:3] == 2'b10);

  always_comb begin
    cond_true = 1'b0;
    if (is_cond) begin
      case (opcode[2:0])
        3'd0: cond_true = (opnd_b & opnd_a) != '0;
        3'd1: cond_true = (opnd_b & opnd_a) == '0;
        3'd2: cond_true = opnd_b == opnd_a;
        3'd3: cond_true = opnd_b != opnd_a;
        3'd4: cond_true = opnd_b > opnd_a;
        3'd5: cond_true = $signed(opnd_b) > $signed(opnd_a);
        3'd6: cond_true = opnd_b < opnd_a;
        default: cond_true = $signed(opnd_b) < $signed(opnd_a);
      endcase
    end
  end

  wire [4:0] w_op   = word_in[4:0];
  wire       w_cond = (w_op[4:3] == 2'b10);
  wire       w_b_ex = (w_op != 5'd0) && takes_word({1'b0, word_in[9:5]});
  wire       w_a_ex = takes_word(word_in[15:10]);
  wire [1:0] w_len  = {1'b0, w_b_ex} + {1'b0, w_a_ex};

  wire head      = skip_q && word_valid && (left_q == 2'd0);
  wire tail_word = skip_q && word_valid && (left_q != 2'd0);
  wire start     = eval_valid && !skip_q && is_cond && !cond_true;
  wire ends_cond = head ? w_cond : chain_q;

  assign drop_done   = (head && w_len == 2'd0) || (tail_word && left_q == 2'd1);
  assign skip_active = skip_q;
  assign extra_cycle = extra_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q  <= 1'b0;
      extra_q <= 1'b0;
      left_q  <= 2'd0;
      chain_q <= 1'b0;
    end else begin
      extra_q <= start;
      if (start)
        skip_q <= 1'b1;
      else if (drop_done && !ends_cond)
        skip_q <= 1'b0;
      if (head) begin
        left_q  <= w_len;
        chain_q <= w_cond;
      end else if (tail_word) begin
        left_q <= left_q - 2'd1;
      end
    end
  end

endmodule

module cond_skip_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       eval_valid,
  input logic [4:0] opcode,
  input logic       word_valid,
  input logic       cond_true,
  input logic       skip_active,
  input logic       extra_cycle,
  input logic       drop_done
);

  AST_FAIL_STARTS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && opcode[4:3] == 2'b10 && !cond_true && !skip_active) |=> (skip_active && extra_cycle)); // R4

  AST_PENALTY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cycle |=> !extra_cycle); // R4

  AST_NO_DROP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_active |-> !drop_done); // R6

  AST_NO_WORD_NO_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_active && !word_valid) |-> (!drop_done ##1 skip_active)); // R9

  AST_EXIT_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(skip_active) |-> $past(drop_done)); // R8

  AST_NONCOND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip_active && !(eval_valid && opcode[4:3] == 2'b10)) |=> !extra_cycle); // R5

endmodule

bind cond_skip_unit cond_skip_checks u_checks (
  .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .opcode(opcode),
  .word_valid(word_valid), .cond_true(cond_true), .skip_active(skip_active),
  .extra_cycle(extra_cycle), .drop_done(drop_done)
);

// File: tb/sim_cond_skip_unit.sv
module sim_cond_skip_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam logic [37:0] VEC [NVEC] = '{
    {5'h10, 16'hF0F0, 16'h0F0F, 1'b0},
    {5'h10, 16'hF1F0, 16'h0F0F, 1'b1},
    {5'h11, 16'hF0F0, 16'h0F0F, 1'b1},
    {5'h11, 16'h0001, 16'h0003, 1'b0},
    {5'h12, 16'h0017, 16'h0017, 1'b1},
    {5'h12, 16'h0017, 16'h0018, 1'b0},
    {5'h13, 16'h1234, 16'h1235, 1'b1},
    {5'h14, 16'h8000, 16'h0001, 1'b1},
    {5'h15, 16'h8000, 16'h0001, 1'b0},
    {5'h15, 16'h0001, 16'hFFFF, 1'b1},
    {5'h16, 16'h0001, 16'h8000, 1'b1},
    {5'h17, 16'hFFFF, 16'h0001, 1'b1},
    {5'h17, 16'h0005, 16'h0005, 1'b0},
    {5'h02, 16'h0000, 16'h0001, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_valid = 1'b0;
  logic [4:0] opcode = '0;
  logic [15:0] opnd_b = '0, opnd_a = '0, word_in = '0;
  logic word_valid = 1'b0;
  logic cond_true, skip_active, extra_cycle, drop_done;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_skip_unit u0 (.clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .opcode(opcode),
    .opnd_b(opnd_b), .opnd_a(opnd_a), .word_valid(word_valid), .word_in(word_in),
    .cond_true(cond_true), .skip_active(skip_active), .extra_cycle(extra_cycle),
    .drop_done(drop_done));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic idle();
    eval_valid = 0; word_valid = 0;
  endtask

  task automatic fail_eval();
    eval_valid = 1; opcode = 5'h12; opnd_b = 16'd1; opnd_a = 16'd2;
    step(); idle();
  endtask

  task automatic feed(input logic [15:0] w, input logic exp_drop, input string req);
    word_valid = 1; word_in = w; #1;
    chk(req, drop_done, exp_drop);
    step(); word_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); step(); #1;
    chk("R1 skip", skip_active, 0); chk("R1 extra", extra_cycle, 0); chk("R1 drop", drop_done, 0);
    rst_n = 1; step();

    for (int i = 0; i < NVEC; i++) begin
      opcode = VEC[i][37:33]; opnd_b = VEC[i][32:17]; opnd_a = VEC[i][16:1]; #1;
      chk((opcode == 5'h15 || opcode == 5'h17) ? "R3 vector" : "R2 vector", cond_true, VEC[i][0]);
    end

    eval_valid = 1; opcode = 5'h12; opnd_b = 16'd5; opnd_a = 16'd5;
    step(); idle();
    chk("R4 pass no skip", skip_active, 0); chk("R4 pass no extra", extra_cycle, 0);

    eval_valid = 1; opcode = 5'h02; opnd_b = 16'd1; opnd_a = 16'd2;
    step(); idle();
    chk("R5 noncond skip", skip_active, 0); chk("R5 noncond extra", extra_cycle, 0);

    fail_eval();
    chk("R4 skip", skip_active, 1); chk("R4 extra", extra_cycle, 1);
    eval_valid = 1; opcode = 5'h13; opnd_b = 16'd3; opnd_a = 16'd3;
    step(); idle();
    chk("R4 extra one cycle", extra_cycle, 0);
    chk("R5 eval while skipping extra", extra_cycle, 0);
    step();
    chk("R9 still skipping", skip_active, 1);
    chk("R9 no drop", drop_done, 0);
    feed(16'h7C01, 0, "R6 head of 2-word");
    feed(16'h0030, 1, "R6 literal end");
    chk("R6 skip ends", skip_active, 0);

    fail_eval(); step();
    feed(16'h7FD3, 0, "R6 3-word head");
    feed(16'h1111, 0, "R6 3-word mid");
    feed(16'h2222, 1, "R6 3-word end");
    chk("R8 chain keeps skipping", skip_active, 1);
    feed(16'h0017, 1, "R8 1-word cond");
    chk("R8 chain again", skip_active, 1);
    feed(16'h0001, 1, "R6 1-word plain");
    chk("R8 chain ends", skip_active, 0);

    fail_eval(); step();
    feed(16'h87E0, 1, "R7 special b ignored");
    chk("R7 special not cond", skip_active, 0);
    fail_eval(); step();
    feed(16'h43E0, 0, "R7 special a word head");
    feed(16'h0000, 1, "R7 special a word end");
    chk("R7 skip ends", skip_active, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule